// File: doc/BRIEF.md
# SDRAM Bank Row-Timing Sequencer

This block turns read requests aimed at a single SDRAM bank into a timed stream of row-open, column-read and row-close commands. Each request carries a row and a column. The block remembers whether a row is open in the bank and which row it is. It sorts every accepted request into one of three classes. A row hit needs only the column read. A closed-bank access needs a row open and then the read. A row conflict needs the wrong row closed, the new row opened, and then the read.

Every command goes out at the earliest cycle that meets the run-time minimum cycle counts. Those minimums cover three gaps: row open to read, close to the next open, and open to close. An optional two-cycle command spacing can be enabled. A data-valid strobe follows each read by exactly the programmed CAS latency. Two fixed register stages sit between accepting a request and its first possible command. As a result, the request-to-data latency is 2 + CL cycles for a hit, 2 + tRCD + CL for a closed bank, and longer when a conflict has to wait out its timers.

Top module: `sdram_row_seq`

## Requirements
- R1: When reset is released, the bank counts as closed and every timer counts as already met. In that state req_ready is 1 and cmd_valid, rd_valid and the three class flags are 0. The first accepted request is therefore classed as closed-bank.
- R2: For each accepted request (req_valid and req_ready both high in a cycle), exactly one of row_hit, row_miss or row_conflict is 1 in the following cycle. row_hit means the open row equals the requested row. row_miss means no row is open. row_conflict means a different row is open. Otherwise all three are 0.
- R3: A read (cmd_kind 2) goes out no fewer than max(cfg_trcd,1) cycles after the latest row open (cmd_kind 1).
- R4: A row open goes out no fewer than max(cfg_trp,1) cycles after the latest row close (cmd_kind 3).
- R5: A row close goes out no fewer than max(cfg_tras,1) cycles after the latest row open.
- R6: rd_valid is 1 in exactly the cycles that lie max(cfg_cl,1) cycles after a read command cycle, and in no other cycle.
- R7: With cfg_2t = 1, two commands are at least 2 cycles apart. With cfg_2t = 0, they may go out in consecutive cycles.
- R8: Every command goes out at the earliest cycle that meets R3, R4, R5 and R7, and never earlier than 2 cycles after its request was accepted.
- R9: A timing input of 0 acts as 1. With all timings at 0, data is valid 1 cycle after its read.
- R10: A hit issues only a read. A closed-bank request issues an open and then a read. A conflict issues a close, then an open, then a read.
- R11: cmd_row carries the request's row during an open, and cmd_col carries its column during a read. Both are 0 in every other cycle.
- R12: req_ready is 1 exactly when no accepted request still lacks its read. This includes the cycle in which the previous read goes out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_row | input | ROW_W | Requested row |
| req_col | input | COL_W | Requested column |
| cfg_cl | input | TW | CAS latency in cycles (0 acts as 1) |
| cfg_trcd | input | TW | Open-to-read minimum |
| cfg_trp | input | TW | Close-to-open minimum |
| cfg_tras | input | TW | Open-to-close minimum |
| cfg_2t | input | 1 | 1 = two-cycle command spacing |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd_kind | output | 2 | 0 none, 1 open, 2 read, 3 close |
| cmd_row | output | ROW_W | Row of an open command, else 0 |
| cmd_col | output | COL_W | Column of a read command, else 0 |
| rd_valid | output | 1 | Read data valid strobe |
| row_hit | output | 1 | Accepted request hit the open row |
| row_miss | output | 1 | Accepted request found the bank closed |
| row_conflict | output | 1 | Accepted request found another row open |

## Verification
The assertions assume that the timing and spacing inputs stay constant from the moment a request is accepted until the CAS latency of its read has run out. The checks compare elapsed-cycle counters against the latched settings, and the data-valid tap depends on a stable CL. The stimulus changes settings only after a long idle drain with nothing pending. Requests draw from a small pool of rows so that hits, closed-bank accesses and conflicts all occur. Random idle gaps are mixed in, and directed runs cover all-zero timings and the largest values.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_ACT  = 2'd1,
    CMD_RD   = 2'd2,
    CMD_PRE  = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CLOSE = 2'd1,
    ST_OPEN = 2'd2,
    ST_READ = 2'd3
  } seq_st_e;

  localparam int TMR_ACT = 0;
  localparam int TMR_PRE = 1;
  localparam int TMR_ANY = 2;
  localparam int N_TMR   = 3;
endpackage

// File: rtl/seq_elapsed_ctr.sv
module seq_elapsed_ctr #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] SAT = '1;

  // Reset to saturation: all windows count as long expired.
  always_ff @(posedge clk) begin
    if (rst)               count <= SAT;
    else if (clear)        count <= '0;
    else if (count != SAT) count <= count + 1'b1;
  end
endmodule

// File: rtl/seq_cas_delay.sv
module seq_cas_delay #(
  parameter int DEPTH = 64,
  parameter int SW    = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift_in,
  input  logic [SW-1:0] tap_sel,
  output logic          tap_out
);
  logic [DEPTH-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe    <= '0;
      tap_out <= 1'b0;
    end else begin
      pipe    <= {pipe[DEPTH-2:0], shift_in};
      tap_out <= pipe[tap_sel];
    end
  end
endmodule

// File: rtl/sdram_row_seq.sv
module sdram_row_seq
  import sdram_seq_pkg::*;
#(
  parameter int ROW_W = 13,
  parameter int COL_W = 10,
  parameter int TW    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic [TW-1:0]    cfg_cl,
  input  logic [TW-1:0]    cfg_trcd,
  input  logic [TW-1:0]    cfg_trp,
  input  logic [TW-1:0]    cfg_tras,
  input  logic             cfg_2t,
  output logic             cmd_valid,
  output logic [1:0]       cmd_kind,
  output logic [ROW_W-1:0] cmd_row,
  output logic [COL_W-1:0] cmd_col,
  output logic             rd_valid,
  output logic             row_hit,
  output logic             row_miss,
  output logic             row_conflict
);
  localparam int CW    = TW + 1;
  localparam int DEPTH = 1 << TW;
  localparam logic [CW-1:0] ONE_C = 1;
  localparam logic [TW-1:0] ONE_T = 1;

  function automatic logic [TW-1:0] eff(input logic [TW-1:0] v);
    return (v == '0) ? ONE_T : v;
  endfunction

  seq_st_e          state;
  cmd_e             kind_q;
  logic             row_open;
  logic [ROW_W-1:0] open_row;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;

  // Latched timing set, refreshed only while idle
  logic [TW-1:0] cl_q, trcd_q, trp_q, tras_q;
  logic          rate2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cl_q    <= ONE_T;
      trcd_q  <= ONE_T;
      trp_q   <= ONE_T;
      tras_q  <= ONE_T;
      rate2_q <= 1'b0;
    end else if (state == ST_IDLE) begin
      cl_q    <= eff(cfg_cl);
      trcd_q  <= eff(cfg_trcd);
      trp_q   <= eff(cfg_trp);
      tras_q  <= eff(cfg_tras);
      rate2_q <= cfg_2t;
    end
  end

  // Elapsed-cycle timers, zero in the cycle their command is on the outputs
  logic [N_TMR-1:0] tmr_clr;
  logic [CW-1:0]    tmr_cnt [N_TMR];

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    seq_elapsed_ctr #(.CW(CW)) u_ctr (
      .clk   (clk),
      .rst   (rst),
      .clear (tmr_clr[g]),
      .count (tmr_cnt[g])
    );
  end

  logic since_act_ok_rcd, since_act_ok_ras, since_pre_ok, gap_ok;
  logic issue_pre, issue_act, issue_rd;

  // A command decided now appears next cycle, hence the minus one
  always_comb begin
    since_act_ok_rcd = tmr_cnt[TMR_ACT] >= ({1'b0, trcd_q} - ONE_C);
    since_act_ok_ras = tmr_cnt[TMR_ACT] >= ({1'b0, tras_q} - ONE_C);
    since_pre_ok     = tmr_cnt[TMR_PRE] >= ({1'b0, trp_q} - ONE_C);
    gap_ok           = !rate2_q || (tmr_cnt[TMR_ANY] != '0);
    issue_pre = (state == ST_CLOSE) && since_act_ok_ras && gap_ok;
    issue_act = (state == ST_OPEN)  && since_pre_ok     && gap_ok;
    issue_rd  = (state == ST_READ)  && since_act_ok_rcd && gap_ok;
    tmr_clr[TMR_ACT] = issue_act;
    tmr_clr[TMR_PRE] = issue_pre;
    tmr_clr[TMR_ANY] = issue_pre | issue_act | issue_rd;
  end

  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      row_open     <= 1'b0;
      open_row     <= '0;
      row_q        <= '0;
      col_q        <= '0;
      kind_q       <= CMD_NONE;
      cmd_valid    <= 1'b0;
      cmd_row      <= '0;
      cmd_col      <= '0;
      row_hit      <= 1'b0;
      row_miss     <= 1'b0;
      row_conflict <= 1'b0;
    end else begin
      kind_q       <= CMD_NONE;
      cmd_valid    <= 1'b0;
      cmd_row      <= '0;
      cmd_col      <= '0;
      row_hit      <= 1'b0;
      row_miss     <= 1'b0;
      row_conflict <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            row_q <= req_row;
            col_q <= req_col;
            if (!row_open) begin
              row_miss <= 1'b1;
              state    <= ST_OPEN;
            end else if (open_row == req_row) begin
              row_hit <= 1'b1;
              state   <= ST_READ;
            end else begin
              row_conflict <= 1'b1;
              state        <= ST_CLOSE;
            end
          end
        end
        ST_CLOSE: begin
          if (issue_pre) begin
            kind_q    <= CMD_PRE;
            cmd_valid <= 1'b1;
            row_open  <= 1'b0;
            state     <= ST_OPEN;
          end
        end
        ST_OPEN: begin
          if (issue_act) begin
            kind_q    <= CMD_ACT;
            cmd_valid <= 1'b1;
            cmd_row   <= row_q;
            row_open  <= 1'b1;
            open_row  <= row_q;
            state     <= ST_READ;
          end
        end
        ST_READ: begin
          if (issue_rd) begin
            kind_q    <= CMD_RD;
            cmd_valid <= 1'b1;
            cmd_col   <= col_q;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_kind = kind_q;

  seq_cas_delay #(.DEPTH(DEPTH), .SW(TW)) u_cas (
    .clk      (clk),
    .rst      (rst),
    .shift_in (issue_rd),
    .tap_sel  (cl_q - ONE_T),
    .tap_out  (rd_valid)
  );

  // R1: state right after reset
  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (req_ready && !cmd_valid && !rd_valid && !row_open));

  // R2: at most one class flag
  a_r2_one_class: assert property (@(posedge clk) disable iff (rst)
    $onehot0({row_hit, row_miss, row_conflict}));

  // R3: read respects open-to-read minimum
  a_r3_rcd_met: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && kind_q == CMD_RD) |-> (tmr_cnt[TMR_ACT] >= {1'b0, trcd_q}));

  // R4: open respects close-to-open minimum
  a_r4_rp_met: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && kind_q == CMD_ACT) |-> (tmr_cnt[TMR_PRE] >= {1'b0, trp_q}));

  // R5: close respects open-to-close minimum
  a_r5_ras_met: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && kind_q == CMD_PRE) |-> (tmr_cnt[TMR_ACT] >= {1'b0, tras_q}));

  // R7: two-cycle spacing
  a_r7_two_cycle_gap: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && rate2_q) |=> !cmd_valid);

  // R10: a close leaves the bank closed, an open leaves it open
  a_r10_close_state: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && kind_q == CMD_PRE) |-> !row_open);
  a_r10_open_state: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && kind_q == CMD_ACT) |-> (row_open && open_row == cmd_row));
endmodule

// File: tb/sdram_row_seq_tb.sv
module sdram_row_seq_tb;
  localparam int ROW_W = 13;
  localparam int COL_W = 10;
  localparam int TW    = 6;
  localparam int RING  = 512;
  localparam int NEVER = -100000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic [TW-1:0]    cfg_cl = 6'd1, cfg_trcd = 6'd1, cfg_trp = 6'd1, cfg_tras = 6'd1;
  logic             cfg_2t = 1'b0;
  logic             cmd_valid;
  logic [1:0]       cmd_kind;
  logic [ROW_W-1:0] cmd_row;
  logic [COL_W-1:0] cmd_col;
  logic             rd_valid, row_hit, row_miss, row_conflict;

  always #5 clk = ~clk;

  sdram_row_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .TW(TW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_col(req_col), .cfg_cl(cfg_cl), .cfg_trcd(cfg_trcd),
    .cfg_trp(cfg_trp), .cfg_tras(cfg_tras), .cfg_2t(cfg_2t),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .rd_valid(rd_valid), .row_hit(row_hit), .row_miss(row_miss), .row_conflict(row_conflict)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int eff(input logic [TW-1:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction
  function automatic int max3(input int a, input int b, input int c);
    int m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

  // Expectation rings indexed by cycle
  int exp_kind [RING];
  int exp_row  [RING];
  int exp_col  [RING];
  int exp_cls  [RING];
  bit exp_rd   [RING];

  // Reference bank model
  bit m_open = 0;
  int m_row  = 0;
  int t_act = NEVER, t_pre = NEVER, t_last = NEVER, busy_until = 0;
  bit first_req = 1;

  // Observed history for independent spacing checks
  int o_act = NEVER, o_pre = NEVER, o_any = NEVER, o_rd = NEVER;

  initial begin
    for (int i = 0; i < RING; i++) begin
      exp_kind[i] = 0; exp_row[i] = 0; exp_col[i] = 0; exp_cls[i] = 0; exp_rd[i] = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      int c, k, gap, cls, lb, tp, ta, tr;
      c = cyc;
      k = c % RING;
      // R8 R10 R11: exact command stream
      chk(int'(cmd_kind) == exp_kind[k] && cmd_valid == (exp_kind[k] != 0),
          "R8 R10 command kind", int'(cmd_kind), exp_kind[k]);
      chk(int'(cmd_row) == exp_row[k] && int'(cmd_col) == exp_col[k],
          "R11 command address", int'(cmd_row) * 4096 + int'(cmd_col),
          exp_row[k] * 4096 + exp_col[k]);
      chk(rd_valid == exp_rd[k], "R6 data valid", int'(rd_valid), int'(exp_rd[k]));
      chk(int'({row_conflict, row_miss, row_hit}) ==
          ((exp_cls[k] == 0) ? 0 : (1 << (exp_cls[k] - 1))),
          "R2 class flags", int'({row_conflict, row_miss, row_hit}), exp_cls[k]);
      chk(req_ready == (c >= busy_until), "R12 ready", int'(req_ready), int'(c >= busy_until));
      exp_kind[k] = 0; exp_row[k] = 0; exp_col[k] = 0; exp_rd[k] = 0; exp_cls[k] = 0;

      // Independent minimum-spacing checks on what was observed
      if (cmd_valid) begin
        if (cfg_2t) chk(c - o_any >= 2, "R7 two-cycle spacing", c - o_any, 2);
        if (cmd_kind == 2'd2) begin
          chk(c - o_act >= eff(cfg_trcd), "R3 open-to-read", c - o_act, eff(cfg_trcd));
          o_rd = c;
        end
        if (cmd_kind == 2'd1) begin
          chk(c - o_pre >= eff(cfg_trp), "R4 close-to-open", c - o_pre, eff(cfg_trp));
          o_act = c;
        end
        if (cmd_kind == 2'd3) begin
          chk(c - o_act >= eff(cfg_tras), "R5 open-to-close", c - o_act, eff(cfg_tras));
          o_pre = c;
        end
        o_any = c;
      end
      if (rd_valid && cfg_cl == 0)
        chk(c - o_rd == 1, "R9 zero latency acts as one", c - o_rd, 1);

      // Acceptance: compute expected future
      if (req_valid && req_ready) begin
        gap = cfg_2t ? 2 : 1;
        cls = !m_open ? 2 : ((m_row == int'(req_row)) ? 1 : 3);
        if (first_req) begin
          chk(cls == 2, "R1 first request sees closed bank", cls, 2);
          first_req = 0;
        end
        exp_cls[(c + 1) % RING] = cls;
        lb = c + 2;
        if (cls == 3) begin
          tp = max3(lb, t_act + eff(cfg_tras), t_last + gap);
          exp_kind[tp % RING] = 3;
          t_pre = tp; t_last = tp; lb = tp + 1; m_open = 0;
        end
        if (cls != 1) begin
          ta = max3(lb, t_pre + eff(cfg_trp), t_last + gap);
          exp_kind[ta % RING] = 1;
          exp_row[ta % RING] = int'(req_row);
          t_act = ta; t_last = ta; lb = ta + 1; m_open = 1; m_row = int'(req_row);
        end
        tr = max3(lb, t_act + eff(cfg_trcd), t_last + gap);
        exp_kind[tr % RING] = 2;
        exp_col[tr % RING] = int'(req_col);
        exp_rd[(tr + eff(cfg_cl)) % RING] = 1;
        t_last = tr;
        busy_until = tr;
      end
    end
  end

  task automatic send(input int r, input int col);
    req_valid = 1'b1;
    req_row   = ROW_W'(r);
    req_col   = COL_W'(col);
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic run_phase(input int cl, input int rcd, input int rp, input int ras,
                           input bit two, input int n, input int nrows);
    cfg_cl = TW'(cl); cfg_trcd = TW'(rcd); cfg_trp = TW'(rp); cfg_tras = TW'(ras);
    cfg_2t = two;
    @(posedge clk); #1;
    for (int i = 0; i < n; i++) begin
      send(int'($urandom_range(0, nrows - 1)) * 37 + 5, int'($urandom_range(0, 1023)));
      repeat ($urandom_range(0, 3)) @(posedge clk);
      #1;
    end
    repeat (320) @(posedge clk);
    #1;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    done = 1;
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0017));
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: outputs after reset
    chk(req_ready && !cmd_valid && !rd_valid && !row_hit && !row_miss && !row_conflict,
        "R1 reset state", int'({req_ready, cmd_valid, rd_valid}), 4);
    @(posedge clk); #1;
    run_phase(7, 8, 8, 24, 1'b0, 30, 3);
    run_phase(3, 2, 4, 5, 1'b1, 40, 3);
    // R9: all-zero timings act as one
    run_phase(0, 0, 0, 0, 1'b0, 30, 2);
    run_phase(0, 0, 0, 0, 1'b1, 30, 2);
    // Boundary: largest values
    run_phase(63, 63, 63, 63, 1'b1, 8, 2);
    run_phase(1, 63, 1, 2, 1'b0, 10, 2);
    for (int p = 0; p < 6; p++)
      run_phase(int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
                int'($urandom_range(0, 15)), int'($urandom_range(0, 20)),
                1'($urandom_range(0, 1)), 40, 1 + p % 4);
    done = 1;
    summary();
    $finish;
  end
endmodule